// File: doc/BRIEF.md
# Legacy Serial-Port Resource Selector

This block holds one byte of configuration. A local microcontroller writes it and can read it back. Two 3-bit codes in the byte choose one of eight classic serial-port I/O windows and one of eight interrupt lines for a UART that is emulated on the host side.

When the enable bit is set, the block decodes the host address bus into a chip-select for the chosen 8-byte window. It passes the low address bits through as the register offset. It also routes the UART interrupt request onto a one-hot set of eight interrupt lines. The same write that sets the enable bit copies the chosen base address and IRQ number into the plug-and-play I/O-base and interrupt registers that the block outputs.

A pulse from an external detector marks the plug-and-play initiation key. That pulse revokes the enable at once. A separate flag bit asks the microcontroller to store the current settings as the power-on default. A dedicated input sets this flag, and only the microcontroller can clear it.

Top module: `com_window_cfg`

## Requirements
- R1: After reset, the register reads back as `{2'b00, DEFAULT_SEL}`. The plug-and-play base and IRQ outputs hold the values that DEFAULT_SEL decodes to. `host_cs` is 0 and `irq_lines` is all zero.
- R2: Bits 2:0 of the register are the IRQ code. The codes 0 to 7 give IRQ 10, 11, 12, 15, 3, 4, 5 and 7. The code is also the index of the `irq_lines` bit that is driven.
- R3: Bits 5:3 of the register are the base code. The codes 0 to 7 give the bases 3F8h, 2F8h, 3E8h, 2E8h, 3F0h, 2F0h, 3E0h and 2E0h.
- R4: `host_cs` is 1 only when bit 7 is set and `host_addr[15:3]` equals bits 15:3 of the selected base. While `host_cs` is 1, `host_ofs` equals `host_addr[2:0]`; otherwise `host_ofs` is 0.
- R5: `irq_lines` is one-hot at the IRQ-code index while bit 7 is set and `uart_irq` is 1. Otherwise `irq_lines` is all zero.
- R6: A write with data bit 7 set loads the decoded base and IRQ into the plug-and-play outputs in the same cycle that the register updates. A write with data bit 7 clear updates bits 5:0 but leaves the plug-and-play outputs unchanged.
- R7: A `key_seen` pulse clears bit 7 at the next clock edge. If a write arrives in the same cycle, bit 7 still ends up cleared, and the plug-and-play outputs are not loaded.
- R8: `save_req` sets bit 6. A write of 1 to bit 6 has no effect on it, and a write of 0 clears it. If `save_req` and a write of 0 to bit 6 arrive in the same cycle, bit 6 stays set.
- R9: `mcu_rdata` always shows the current register value: bit 7 is the enable, bit 6 the save flag, bits 5:3 the base code and bits 2:0 the IRQ code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mcu_wr | input | 1 | Microcontroller write strobe |
| mcu_wdata | input | 8 | Microcontroller write data |
| mcu_rdata | output | 8 | Register read-back |
| key_seen | input | 1 | Initiation-key detected pulse |
| save_req | input | 1 | Request to set the save-default flag |
| host_addr | input | 16 | Host I/O address |
| host_cs | output | 1 | Chip-select for the chosen window |
| host_ofs | output | 3 | Register offset inside the window |
| uart_irq | input | 1 | UART interrupt request |
| irq_lines | output | 8 | One-hot routed interrupt, indexed by IRQ code |
| pnp_io_base | output | 16 | Plug-and-play I/O base register |
| pnp_irq_num | output | 4 | Plug-and-play interrupt number register |

## Verification
All eight base codes and all eight IRQ codes are written, each paired with a different partner code. A swapped or mis-decoded table entry therefore shows up in both the plug-and-play outputs and the one-hot line index.

The chip-select is probed at the first and last byte of the window and one window away. This separates a wrong compare width from a wrong base. Writes with the enable bit cleared, key pulses with and without a write in the same cycle, and the save-flag set and clear collisions separate the priority choices from one another.

// File: rtl/com_window_cfg.sv
module com_window_cfg #(
  parameter logic [5:0] DEFAULT_SEL = 6'b001_100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mcu_wr,
  input  logic [7:0]  mcu_wdata,
  output logic [7:0]  mcu_rdata,
  input  logic        key_seen,
  input  logic        save_req,
  input  logic [15:0] host_addr,
  output logic        host_cs,
  output logic [2:0]  host_ofs,
  input  logic        uart_irq,
  output logic [7:0]  irq_lines,
  output logic [15:0] pnp_io_base,
  output logic [3:0]  pnp_irq_num
);

  function automatic logic [15:0] base_of(input logic [2:0] c);
    base_of = 16'h02E0 | {7'd0, ~c[0], 3'd0, ~c[1], ~c[2], 3'd0};
  endfunction

  function automatic logic [3:0] irq_of(input logic [2:0] c);
    case (c)
      3'd0: irq_of = 4'd10;
      3'd1: irq_of = 4'd11;
      3'd2: irq_of = 4'd12;
      3'd3: irq_of = 4'd15;
      3'd4: irq_of = 4'd3;
      3'd5: irq_of = 4'd4;
      3'd6: irq_of = 4'd5;
      default: irq_of = 4'd7;
    endcase
  endfunction

  logic [5:0] sel_q;
  logic       en_q, save_q;
  logic       load;
  logic [15:0] cur_base;

  assign load = mcu_wr && mcu_wdata[7] && !key_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q       <= DEFAULT_SEL;
      en_q        <= 1'b0;
      save_q      <= 1'b0;
      pnp_io_base <= base_of(DEFAULT_SEL[5:3]);
      pnp_irq_num <= irq_of(DEFAULT_SEL[2:0]);
    end else begin
      if (mcu_wr) sel_q <= mcu_wdata[5:0];
      if (key_seen) en_q <= 1'b0;
      else if (mcu_wr) en_q <= mcu_wdata[7];
      if (save_req) save_q <= 1'b1;
      else if (mcu_wr && !mcu_wdata[6]) save_q <= 1'b0;
      if (load) begin
        pnp_io_base <= base_of(mcu_wdata[5:3]);
        pnp_irq_num <= irq_of(mcu_wdata[2:0]);
      end
    end
  end

  assign mcu_rdata = {en_q, save_q, sel_q};
  assign cur_base  = base_of(sel_q[5:3]);
  assign host_cs   = en_q && (host_addr[15:3] == cur_base[15:3]);
  assign host_ofs  = host_cs ? host_addr[2:0] : 3'd0;
  assign irq_lines = (en_q && uart_irq) ? (8'd1 << sel_q[2:0]) : 8'd0;

  assert_irq_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));

  assert_cs_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_cs |-> mcu_rdata[7]);

  assert_key_revokes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    key_seen |=> !mcu_rdata[7] && !host_cs);

  assert_save_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    save_req |=> mcu_rdata[6]);

  assert_save_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_rdata[6] && !(mcu_wr && !mcu_wdata[6])) |=> mcu_rdata[6]);

  assert_pnp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mcu_wr && mcu_wdata[7]) |=> $stable(pnp_io_base) && $stable(pnp_irq_num));

endmodule

// File: tb/com_window_cfg_bench.sv
module com_window_cfg_bench;
  logic clk = 0, rst_n = 0;
  logic mcu_wr = 0, key_seen = 0, save_req = 0, uart_irq = 0;
  logic [7:0] mcu_wdata = 0;
  logic [15:0] host_addr = 0;
  logic [7:0] mcu_rdata, irq_lines;
  logic host_cs;
  logic [2:0] host_ofs;
  logic [15:0] pnp_io_base;
  logic [3:0] pnp_irq_num;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  com_window_cfg u_com_window_cfg (.*);

  // {wdata, expected base, expected irq number}
  localparam logic [27:0] VEC [8] = '{
    {8'h87, 16'h03F8, 4'd7},  {8'h8E, 16'h02F8, 4'd5},
    {8'h95, 16'h03E8, 4'd4},  {8'h9C, 16'h02E8, 4'd3},
    {8'hA3, 16'h03F0, 4'd15}, {8'hAA, 16'h02F0, 4'd12},
    {8'hB1, 16'h03E0, 4'd11}, {8'hB8, 16'h02E0, 4'd10}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [7:0] d, input logic key, input logic sv);
    @(negedge clk);
    mcu_wr = wr; mcu_wdata = d; key_seen = key; save_req = sv;
    @(negedge clk);
    mcu_wr = 0; key_seen = 0; save_req = 0;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    host_addr = 16'h02F8; uart_irq = 1;
    #1;
    chk("R1 rdata", mcu_rdata, 8'h0C);
    chk("R1 base", pnp_io_base, 16'h02F8);
    chk("R1 irq", pnp_irq_num, 4'd3);
    chk("R1 cs", host_cs, 0);
    chk("R1 lines", irq_lines, 0);
    rst_n = 1;

    for (int i = 0; i < 8; i++) begin
      cyc(1, VEC[i][27:20], 0, 0);
      chk("R9 rdata", mcu_rdata, VEC[i][27:20]);
      chk("R3/R6 base", pnp_io_base, VEC[i][19:4]);
      chk("R2/R6 irq", pnp_irq_num, VEC[i][3:0]);
      host_addr = VEC[i][19:4] + 16'd5; uart_irq = 1; #1;
      chk("R4 cs", host_cs, 1);
      chk("R4 ofs", host_ofs, 3'd5);
      chk("R5 lines", irq_lines, 8'd1 << VEC[i][22:20]);
      uart_irq = 0; #1;
      chk("R5 idle", irq_lines, 0);
    end

    cyc(1, 8'h00, 0, 0);
    chk("R6 no load base", pnp_io_base, 16'h02E0);
    chk("R6 no load irq", pnp_irq_num, 4'd10);
    host_addr = 16'h03F8; #1;
    chk("R4 disabled cs", host_cs, 0);
    chk("R4 disabled ofs", host_ofs, 0);

    cyc(1, 8'h87, 0, 0);
    host_addr = 16'h03FF; #1;
    chk("R4 last byte cs", host_cs, 1);
    chk("R4 last byte ofs", host_ofs, 3'd7);
    host_addr = 16'h03F0; #1;
    chk("R4 other window", host_cs, 0);
    host_addr = 16'h0400; #1;
    chk("R4 above window", host_cs, 0);

    uart_irq = 1;
    cyc(0, 8'h00, 1, 0);
    chk("R7 key clears", mcu_rdata, 8'h07);
    host_addr = 16'h03F8; #1;
    chk("R7 cs off", host_cs, 0);
    chk("R5 lines off", irq_lines, 0);

    cyc(1, 8'h8E, 1, 0);
    chk("R7 key wins", mcu_rdata, 8'h0E);
    chk("R7 no load", pnp_io_base, 16'h03F8);
    uart_irq = 0;

    cyc(0, 8'h00, 0, 1);
    chk("R8 set", mcu_rdata[6], 1);
    cyc(1, 8'h4E, 0, 0);
    chk("R8 write one", mcu_rdata, 8'h4E);
    cyc(1, 8'h0E, 0, 1);
    chk("R8 set wins", mcu_rdata[6], 1);
    cyc(1, 8'h0E, 0, 0);
    chk("R8 cleared", mcu_rdata, 8'h0E);
    cyc(1, 8'h40, 0, 0);
    chk("R8 write one no set", mcu_rdata[6], 0);

    cyc(1, 8'hFF, 0, 1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; #1;
    chk("R1 rerst rdata", mcu_rdata, 8'h0C);
    chk("R1 rerst base", pnp_io_base, 16'h02F8);
    chk("R1 rerst irq", pnp_irq_num, 4'd3);

    done = 1;
    report();
  end
endmodule